// File: doc/BRIEF.md
# Link Rate Change Sequencer

This block moves a serial link to a new transfer rate without software help. A client asks for a rate with a one-hot code. The block then runs a fixed series of register accesses on a small bus master port. If the link already runs at the asked rate, it stops after a single status read. Otherwise it does the following in order:

- masks the low-power link states;
- puts the data-link layer into safe timing;
- waits for the link trainer to settle;
- programs the new rate cap and the matching transmit width;
- issues the speed-change directive, retrying if needed;
- checks the rate actually reached;
- puts back everything it changed.

The block works on four registers, each at an address parameter:

- a link status register, which it only reads;
- a private control register holding the power-state enables;
- a data-link manager register;
- a link configuration register.

Every bus access is a single transfer. The block raises a request and keeps it up until the slave acknowledges. When the sequence ends, the block pulses `done` for one cycle. With it come a 2-bit result code and, on a fatal bus read, a `fatal` flag. Every polling phase has a timeout, counted in clock cycles as a parameter.

Top module: `link_rate_seq`

## Requirements
- R1: A request is valid only when exactly one of `req_speed` bits 0 (2.5 GT/s), 1 (5 GT/s) and 2 (8 GT/s) is set. Any other pattern finishes with result 1 (invalid) and makes no bus access.
- R2: The status register holds the current speed code in bits 19:16 (1 = 2.5, 2 = 5, 3 = 8 GT/s). If that code equals the requested speed, the block finishes with result 0 after one status read and writes nothing.
- R3: Before any rate change, the block sets bits 7 and 8 of the private control register and saves their old values. In cleanup it writes those old values back into the same two bits, leaving the other bits unchanged.
- R4: The block saves the data-link manager register and sets its bit 2 while the change runs. It rewrites the saved value on every exit that follows the save, including timeouts and the fatal abort.
- R5: Before programming, the block reads the config register until bit 4 is 0 and bits 3:0 are 0. If this takes longer than `TIMEOUT_CYCLES`, it goes to cleanup and finishes with result 2 (timeout). Every other polling phase uses the same timeout.
- R6: The new config word keeps the bits just read and changes two fields. Bits 19:18 get the rate cap: 2 for 2.5 GT/s, 1 for 5 GT/s, 0 for 8 GT/s. Bits 22:20 get the transmit width, taken from status bits 25:20: x1 gives 7, x2 gives 6, x4 gives 5, x8 gives 4, x16 gives 0, and any other width gives 7.
- R7: The config word is written and then read back. The write is repeated until the readback matches, subject to the R5 timeout.
- R8: The block writes the word with bits 3:0 = 1 (change speed) and then waits for idle and normal again. If status bits 19:16 still differ from the target, it issues the directive again, up to `MAX_RETRY` (10) more times, so 11 issues at most. If the target is reached, the result is 0.
- R9: If the target is still not reached after the last retry, the block rewrites config bits 19:18 to the encoding of the speed actually reached, using the 2.5 GT/s encoding (2) for an unknown code. It then cleans up and finishes with result 3 (mismatch).
- R10: A config read that returns all ones during a poll aborts to cleanup. The block then finishes with result 3 and `fatal` high in the same cycle as `done`.
- R11: Once raised, `bus_req` stays high, with address, write flag and write data unchanged, until the cycle in which `bus_ack` is high. A new request is taken only while `busy` is low; `req_valid` during a run is ignored.
- R12: `done` lasts exactly one cycle per accepted request. The result codes are 0 = ok, 1 = invalid, 2 = timeout and 3 = mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a rate change, taken while idle |
| req_speed | input | 3 | One-hot target rate |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 2 | Result code, valid with done |
| fatal | output | 1 | Device dropped off the bus, valid with done |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transfer completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
Some properties are checked on every cycle:

- the request-hold rule of the bus handshake;
- silence on the bus while idle;
- the single-cycle `done` pulse;
- `fatal` appearing only with a mismatch result;
- the bounds of the retry count and the timeout counter.

The rest shows only in whole runs against a modelled register slave:

- the encoded rate and width fields;
- restoration of the saved registers;
- the number of directives issued;
- the fallback encoding;
- the abort paths.

The slave model can hold the trainer busy, drop config writes, succeed after a chosen attempt, never settle, or read back all ones.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int REG_W = 32;

  // status register fields
  localparam int ST_SPD_LSB = 16;
  localparam int ST_WID_LSB = 20;
  // private control register power-state enables
  localparam int PV_L0S_BIT = 7;
  localparam int PV_L1_BIT  = 8;
  // data-link manager safe timing bit
  localparam int DL_SAFE_BIT = 2;
  // link config register fields
  localparam int CF_BUSY_BIT = 4;
  localparam int CF_DIR_W    = 4;
  localparam int CF_RATE_LSB = 18;
  localparam int CF_TXW_LSB  = 20;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_INVALID  = 2'd1,
    RES_TIMEOUT  = 2'd2,
    RES_MISMATCH = 2'd3
  } res_e;

  function automatic logic onehot_req(input logic [2:0] oh);
    return (oh == 3'b001) || (oh == 3'b010) || (oh == 3'b100);
  endfunction

  function automatic logic [3:0] speed_code(input logic [2:0] oh);
    case (oh)
      3'b001:  return 4'd1;
      3'b010:  return 4'd2;
      3'b100:  return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

  // rate cap encoding runs opposite to the speed code
  function automatic logic [1:0] rate_field(input logic [3:0] code);
    case (code)
      4'd2:    return 2'd1;
      4'd3:    return 2'd0;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] txw_field(input logic [5:0] lanes);
    case (lanes)
      6'd2:    return 3'd6;
      6'd4:    return 3'd5;
      6'd8:    return 3'd4;
      6'd16:   return 3'd0;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic cfg_settled(input logic [REG_W-1:0] w);
    return !w[CF_BUSY_BIT] && (w[CF_DIR_W-1:0] == '0);
  endfunction
endpackage

// File: rtl/lrs_timer.sv
module lrs_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  assert_timer_cap_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt == LIM) && !restart |=> (cnt == LIM));
endmodule

// File: rtl/lrs_bus_master.sv
module lrs_bus_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DATA_W-1:0] go_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req    <= 1'b0;
          resp_valid <= 1'b1;
          resp_data  <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_wdata;
      end
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata));
endmodule

// File: rtl/link_rate_seq.sv
module link_rate_seq #(
  parameter int unsigned CLK_FREQ_HZ    = 250_000_000,
  parameter int unsigned TIMEOUT_CYCLES = CLK_FREQ_HZ / 2,
  parameter int unsigned MAX_RETRY      = 10,
  parameter int          ADDR_W         = 16,
  parameter int unsigned STAT_ADDR      = 'h0088,
  parameter int unsigned PRIV_ADDR      = 'h0150,
  parameter int unsigned DLM_ADDR       = 'h0400,
  parameter int unsigned CFG_ADDR       = 'h0440
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_speed,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result,
  output logic              fatal,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata
);
  import lrs_pkg::*;

  localparam int RETRY_W = $clog2(MAX_RETRY + 1);
  localparam logic [RETRY_W-1:0] RETRY_LIM = RETRY_W'(MAX_RETRY);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_PRIV = ADDR_W'(PRIV_ADDR);
  localparam logic [ADDR_W-1:0] A_DLM  = ADDR_W'(DLM_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);

  typedef enum logic [4:0] {
    S_IDLE, S_RD_STAT, S_RD_PRIV, S_WR_PRIV, S_RD_DLM, S_WR_DLM,
    S_POLL_IDLE, S_RD_WIDTH, S_WR_CFG, S_CHK_CFG, S_ISSUE, S_POLL_DONE,
    S_RD_RESULT, S_FALLBACK, S_RST_DLM, S_RD_PRIV2, S_WR_PRIV2, S_DONE
  } st_e;

  st_e               state;
  logic              issued;
  logic [3:0]        target;
  logic [1:0]        saved_pm;      // {L1, L0s}
  logic [REG_W-1:0]  saved_dlm;
  logic [REG_W-1:0]  word_q;
  logic [REG_W-1:0]  cfg_q;
  logic [RETRY_W-1:0] retry_cnt;
  res_e              res_q;
  logic              dropped;
  logic              done_q, fatal_q;
  logic              tmr_restart, tmr_expired;

  logic              acc, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [REG_W-1:0]  acc_wdata;
  logic              resp_valid;
  logic [REG_W-1:0]  rd;

  // access issued in each state
  always_comb begin
    acc = 1'b1; acc_we = 1'b0; acc_addr = A_CFG; acc_wdata = '0;
    case (state)
      S_RD_STAT, S_RD_WIDTH, S_RD_RESULT: acc_addr = A_STAT;
      S_RD_PRIV, S_RD_PRIV2:              acc_addr = A_PRIV;
      S_RD_DLM:                           acc_addr = A_DLM;
      S_POLL_IDLE, S_CHK_CFG, S_POLL_DONE: acc_addr = A_CFG;
      S_WR_PRIV: begin
        acc_we = 1'b1; acc_addr = A_PRIV; acc_wdata = word_q;
        acc_wdata[PV_L0S_BIT] = 1'b1;
        acc_wdata[PV_L1_BIT]  = 1'b1;
      end
      S_WR_PRIV2: begin
        acc_we = 1'b1; acc_addr = A_PRIV; acc_wdata = word_q;
        acc_wdata[PV_L0S_BIT] = saved_pm[0];
        acc_wdata[PV_L1_BIT]  = saved_pm[1];
      end
      S_WR_DLM: begin
        acc_we = 1'b1; acc_addr = A_DLM; acc_wdata = saved_dlm;
        acc_wdata[DL_SAFE_BIT] = 1'b1;
      end
      S_RST_DLM: begin
        acc_we = 1'b1; acc_addr = A_DLM; acc_wdata = saved_dlm;
      end
      S_WR_CFG, S_FALLBACK: begin
        acc_we = 1'b1; acc_wdata = cfg_q;
      end
      S_ISSUE: begin
        acc_we = 1'b1;
        acc_wdata = {cfg_q[REG_W-1:CF_DIR_W], 4'h1};
      end
      default: acc = 1'b0;
    endcase
  end

  lrs_bus_master #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_bus (
    .clk(clk), .rst(rst),
    .go(acc && !issued), .go_we(acc_we), .go_addr(acc_addr), .go_wdata(acc_wdata),
    .resp_valid(resp_valid), .resp_data(rd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  lrs_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .restart(tmr_restart), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; issued <= 1'b0; target <= '0; saved_pm <= '0;
      saved_dlm <= '0; word_q <= '0; cfg_q <= '0; retry_cnt <= '0;
      res_q <= RES_OK; dropped <= 1'b0; done_q <= 1'b0; fatal_q <= 1'b0;
      tmr_restart <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      fatal_q     <= 1'b0;
      tmr_restart <= 1'b0;
      if (acc && !issued) issued <= 1'b1;
      if (resp_valid) issued <= 1'b0;

      case (state)
        S_IDLE: if (req_valid) begin
          dropped <= 1'b0;
          if (!onehot_req(req_speed)) begin
            res_q <= RES_INVALID;
            state <= S_DONE;
          end else begin
            target <= speed_code(req_speed);
            state  <= S_RD_STAT;
          end
        end
        S_DONE: begin
          done_q  <= 1'b1;
          fatal_q <= dropped;
          state   <= S_IDLE;
        end
        default: if (resp_valid) begin
          case (state)
            S_RD_STAT:
              if (rd[ST_SPD_LSB +: 4] == target) begin
                res_q <= RES_OK; state <= S_DONE;
              end else state <= S_RD_PRIV;
            S_RD_PRIV: begin
              word_q   <= rd;
              saved_pm <= {rd[PV_L1_BIT], rd[PV_L0S_BIT]};
              state    <= S_WR_PRIV;
            end
            S_WR_PRIV: state <= S_RD_DLM;
            S_RD_DLM: begin saved_dlm <= rd; state <= S_WR_DLM; end
            S_WR_DLM: begin tmr_restart <= 1'b1; state <= S_POLL_IDLE; end
            S_POLL_IDLE:
              if (&rd) begin
                dropped <= 1'b1; res_q <= RES_MISMATCH; state <= S_RST_DLM;
              end else if (cfg_settled(rd)) begin
                cfg_q <= rd; state <= S_RD_WIDTH;
              end else if (tmr_expired) begin
                res_q <= RES_TIMEOUT; state <= S_RST_DLM;
              end
            S_RD_WIDTH: begin
              cfg_q[CF_RATE_LSB +: 2] <= rate_field(target);
              cfg_q[CF_TXW_LSB +: 3]  <= txw_field(rd[ST_WID_LSB +: 6]);
              tmr_restart <= 1'b1;
              state <= S_WR_CFG;
            end
            S_WR_CFG: state <= S_CHK_CFG;
            S_CHK_CFG:
              if (rd == cfg_q) begin
                retry_cnt <= '0; state <= S_ISSUE;
              end else if (tmr_expired) begin
                res_q <= RES_TIMEOUT; state <= S_RST_DLM;
              end else state <= S_WR_CFG;
            S_ISSUE: begin tmr_restart <= 1'b1; state <= S_POLL_DONE; end
            S_POLL_DONE:
              if (&rd) begin
                dropped <= 1'b1; res_q <= RES_MISMATCH; state <= S_RST_DLM;
              end else if (cfg_settled(rd)) begin
                cfg_q <= rd; state <= S_RD_RESULT;
              end else if (tmr_expired) begin
                res_q <= RES_TIMEOUT; state <= S_RST_DLM;
              end
            S_RD_RESULT:
              if (rd[ST_SPD_LSB +: 4] == target) begin
                res_q <= RES_OK; state <= S_RST_DLM;
              end else if (retry_cnt < RETRY_LIM) begin
                retry_cnt <= retry_cnt + 1'b1; state <= S_ISSUE;
              end else begin
                cfg_q[CF_RATE_LSB +: 2] <= rate_field(rd[ST_SPD_LSB +: 4]);
                res_q <= RES_MISMATCH;
                state <= S_FALLBACK;
              end
            S_FALLBACK: state <= S_RST_DLM;
            S_RST_DLM:  state <= S_RD_PRIV2;
            S_RD_PRIV2: begin word_q <= rd; state <= S_WR_PRIV2; end
            S_WR_PRIV2: state <= S_DONE;
            default:    state <= S_IDLE;
          endcase
        end
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign fatal  = fatal_q;

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_fatal_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    fatal |-> done && (result == 2'd3));
  assert_retry_bound_R8: assert property (@(posedge clk) disable iff (rst)
    retry_cnt <= RETRY_LIM);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
endmodule

// File: tb/sim_link_rate_seq.sv
module sim_link_rate_seq;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] A_STAT = 16'h0088, A_PRIV = 16'h0150,
                                A_DLM = 16'h0400, A_CFG = 16'h0440;
  localparam logic [31:0] PRIV_INIT = 32'h0000_0100;
  localparam logic [31:0] DLM_INIT  = 32'h0000_0011;
  localparam logic [31:0] CFG_INIT  = 32'h0000_0A00;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic req_valid = 1'b0;
  logic [2:0] req_speed = '0;
  logic busy, done, fatal, bus_req, bus_we, bus_ack;
  logic [1:0] result;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  link_rate_seq #(.TIMEOUT_CYCLES(300), .MAX_RETRY(10), .ADDR_W(ADDR_W),
    .STAT_ADDR('h0088), .PRIV_ADDR('h0150), .DLM_ADDR('h0400), .CFG_ADDR('h0440)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_speed(req_speed),
    .busy(busy), .done(done), .result(result), .fatal(fatal),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  // ---------------- register slave model ----------------
  logic        load = 1'b0;
  logic [31:0] k_stat;
  logic [3:0]  k_succ, k_busy;
  logic [10:0] k_drop;
  logic        k_nidle, k_ones;

  logic [31:0] stat, priv, dlm, cfg, snap_priv, snap_dlm, v;
  logic [3:0]  busy_left, dir_cnt;
  logic [10:0] drop_left;
  int          acc_cnt, wr_cnt;

  always @(posedge clk) begin
    if (load) begin
      stat <= k_stat; priv <= PRIV_INIT; dlm <= DLM_INIT; cfg <= CFG_INIT;
      busy_left <= k_busy; drop_left <= k_drop; dir_cnt <= '0;
      snap_priv <= '0; snap_dlm <= '0; acc_cnt <= 0; wr_cnt <= 0;
      bus_ack <= 1'b0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && !bus_ack) begin
        acc_cnt <= acc_cnt + 1;
        if (bus_we) begin
          wr_cnt <= wr_cnt + 1;
          if (bus_addr == A_PRIV) priv <= bus_wdata;
          else if (bus_addr == A_DLM) dlm <= bus_wdata;
          else if (bus_addr == A_CFG) begin
            if (bus_wdata[3:0] == 4'h1) begin
              cfg <= bus_wdata; dir_cnt <= dir_cnt + 1'b1;
              if (dir_cnt == 0) begin snap_priv <= priv; snap_dlm <= dlm; end
            end else if (drop_left != 0) drop_left <= drop_left - 1'b1;
            else cfg <= bus_wdata;
          end
        end else begin
          v = 32'h0;
          if (bus_addr == A_STAT) v = stat;
          else if (bus_addr == A_PRIV) v = priv;
          else if (bus_addr == A_DLM) v = dlm;
          else if (bus_addr == A_CFG) begin
            v = cfg;
            if (k_ones) v = 32'hFFFF_FFFF;
            else if (k_nidle) v[4] = 1'b1;
            else if (busy_left != 0) begin v[4] = 1'b1; busy_left <= busy_left - 1'b1; end
            else if (cfg[3:0] == 4'h1) begin
              v[3:0] = 4'h0; cfg[3:0] <= 4'h0;
              if (k_succ != 0 && dir_cnt >= k_succ)
                stat[19:16] <= (cfg[19:18] == 2'd2) ? 4'd1 :
                               (cfg[19:18] == 2'd1) ? 4'd2 :
                               (cfg[19:18] == 2'd0) ? 4'd3 : 4'd1;
            end
          end
          bus_rdata <= v;
        end
      end
    end
  end

  // ---------------- monitor ----------------
  int n_done = 0;
  logic [1:0] last_res;
  logic last_fatal;
  always @(negedge clk) if (!rst && done) begin
    n_done <= n_done + 1; last_res <= result; last_fatal <= fatal;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // ---------------- vectors ----------------
  typedef struct packed {
    logic [2:0] req;  logic [3:0] spd; logic [5:0] wid; logic [3:0] succ;
    logic [3:0] bsy;  logic [10:0] drop; logic nidle; logic [1:0] res;
    logic [3:0] dirs; logic chk; logic [1:0] rate; logic [2:0] txw;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{3'b010, 4'd1, 6'd4,  4'd1,  4'd2, 11'd0,    1'b0, 2'd0, 4'd1,  1'b1, 2'd1, 3'd5},
    '{3'b001, 4'd3, 6'd16, 4'd3,  4'd0, 11'd2,    1'b0, 2'd0, 4'd3,  1'b1, 2'd2, 3'd0},
    '{3'b100, 4'd1, 6'd1,  4'd0,  4'd0, 11'd0,    1'b0, 2'd3, 4'd11, 1'b1, 2'd2, 3'd7},
    '{3'b010, 4'd2, 6'd8,  4'd0,  4'd0, 11'd0,    1'b0, 2'd0, 4'd0,  1'b0, 2'd0, 3'd0},
    '{3'b000, 4'd1, 6'd4,  4'd1,  4'd0, 11'd0,    1'b0, 2'd1, 4'd0,  1'b0, 2'd0, 3'd0},
    '{3'b011, 4'd1, 6'd4,  4'd1,  4'd0, 11'd0,    1'b0, 2'd1, 4'd0,  1'b0, 2'd0, 3'd0},
    '{3'b100, 4'd1, 6'd8,  4'd1,  4'd0, 11'd0,    1'b1, 2'd2, 4'd0,  1'b0, 2'd0, 3'd0},
    '{3'b100, 4'd1, 6'd2,  4'd11, 4'd1, 11'd0,    1'b0, 2'd0, 4'd11, 1'b1, 2'd0, 3'd6},
    '{3'b010, 4'd0, 6'd1,  4'd0,  4'd0, 11'd0,    1'b0, 2'd3, 4'd11, 1'b1, 2'd2, 3'd7},
    '{3'b001, 4'd3, 6'd4,  4'd1,  4'd0, 11'd2000, 1'b0, 2'd2, 4'd0,  1'b0, 2'd0, 3'd0},
    '{3'b100, 4'd2, 6'd16, 4'd1,  4'd0, 11'd0,    1'b0, 2'd0, 4'd1,  1'b1, 2'd0, 3'd0}
  };

  task automatic setup(input vec_t t, input logic ones);
    @(negedge clk);
    k_stat = {6'd0, t.wid, t.spd, 16'h0};
    k_succ = t.succ; k_busy = t.bsy; k_drop = t.drop; k_nidle = t.nidle; k_ones = ones;
    load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic start(input logic [2:0] s);
    @(negedge clk); req_valid = 1'b1; req_speed = s;
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic wait_done(input int base, input string tag);
    for (int i = 0; i < 6000 && n_done == base; i++) @(negedge clk);
    chk(n_done == base + 1, {tag, " done"}, n_done, base + 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t t;
    int b;
    k_stat = '0; k_succ = '0; k_busy = '0; k_drop = '0; k_nidle = 1'b0; k_ones = 1'b0;
    bus_rdata = '0;
    load = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0; load = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_req && result == 2'd0, "R12 reset state",
        {busy, done, bus_req, result}, 0);

    for (int i = 0; i < NV; i++) begin
      t = VT[i];
      setup(t, 1'b0);
      b = n_done;
      start(t.req);
      wait_done(b, "R12");
      repeat (3) @(negedge clk);
      chk(last_res == t.res, "R1/R2/R5/R8/R9 result", last_res, t.res);
      chk(!last_fatal, "R10 no fatal", last_fatal, 0);
      chk(dir_cnt == t.dirs, "R8 directive count", dir_cnt, t.dirs);
      if (t.res == 2'd1)
        chk(acc_cnt == 0, "R1 no bus access", acc_cnt, 0);
      else if (t.res == 2'd0 && t.dirs == 0)
        chk(wr_cnt == 0 && acc_cnt == 1, "R2 single read no write", wr_cnt, 0);
      else begin
        chk(dlm == DLM_INIT, "R4 dlm restored", dlm, DLM_INIT);
        chk(priv == PRIV_INIT, "R3 priv restored", priv, PRIV_INIT);
      end
      if (t.dirs != 0) begin
        chk(snap_priv[8:7] == 2'b11, "R3 power states masked", snap_priv, 32'h180);
        chk(snap_dlm[2], "R4 safe timing set", snap_dlm, DLM_INIT | 32'h4);
      end
      if (t.chk) begin
        chk(cfg[19:18] == t.rate, "R6/R9 rate field", cfg[19:18], t.rate);
        chk(cfg[22:20] == t.txw, "R6 width field", cfg[22:20], t.txw);
        chk(cfg[11:8] == CFG_INIT[11:8], "R7 other bits kept", cfg, CFG_INIT);
      end else
        chk(cfg == CFG_INIT, "R5/R7 cfg untouched", cfg, CFG_INIT);
    end

    // device drops off the bus
    t = VT[0];
    setup(t, 1'b1);
    b = n_done;
    start(3'b100);
    wait_done(b, "R10");
    repeat (3) @(negedge clk);
    chk(last_fatal && last_res == 2'd3, "R10 fatal flagged", {last_fatal, last_res}, 3'b111);
    chk(dlm == DLM_INIT, "R10/R4 dlm restored after abort", dlm, DLM_INIT);
    chk(priv == PRIV_INIT, "R10/R3 priv restored after abort", priv, PRIV_INIT);

    // request during a run is ignored
    t = VT[1];
    setup(t, 1'b0);
    b = n_done;
    start(3'b001);
    repeat (10) @(negedge clk);
    chk(busy, "R11 busy during run", busy, 1);
    req_valid = 1'b1; req_speed = 3'b000;
    @(negedge clk); req_valid = 1'b0;
    wait_done(b, "R11");
    repeat (40) @(negedge clk);
    chk(n_done == b + 1, "R11 one done only", n_done, b + 1);
    chk(last_res == 2'd0, "R11 busy request ignored", last_res, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule